// File: doc/BRIEF.md
# Period-Match Timer with Synchronized Enable

This block is an up-counter whose count steps are taken from an external timer clock input. It counts up to a programmable period value. On the counting step after the count equals the period, it returns to zero and raises a one-cycle match pulse. The whole block runs on the system clock. The timer clock input passes through a two-flop synchronizer, and the block then detects the edge it needs from the synchronized signal. Three configuration inputs shape the behaviour:

- One selects which edge of the timer input counts.
- One delays the run-enable through a two-stage chain that advances on counting edges, so that starting and stopping happen cleanly in the timer's own time base.
- One holds each count step until the terminal phase of an internal divide-by-four of the system clock, so that the count only changes at predictable instants.

Software uses it as a free-running period timer. It loads the period, picks the edge and the options, and raises the run-enable. The match pulse then marks each period boundary.

Top module: `period_match_timer`

## Requirements
- R1: While reset is asserted, and directly after it is released, the count is 0 and the match pulse is 0. The latched edge selection is rising edge, and no start is pending in the enable chain.
- R2: With `cfg_fall_edge` = 0, a low-to-high transition of `tmr_clk_in` is a counting edge. With `cfg_fall_edge` = 1, a high-to-low transition is a counting edge. The other transition never changes the count.
- R3: The edge selection is latched from `cfg_fall_edge` only while the timer is stopped. While it runs, changes on `cfg_fall_edge` have no effect on which transition counts.
- R4: While the effective run state is 0, counting edges leave the count unchanged. Stopping keeps the value the count had.
- R5: With `cfg_run_sync` = 1, a change on `run_en` takes effect after two counting edges. After a rise, the first two edges do not count and the third does. After a fall, two more edges still count.
- R6: With `cfg_run_sync` = 0, `run_en` acts at once: the first counting edge seen while it is 1 increments the count.
- R7: On each counting step, the count becomes 0 if it equals `period`, and otherwise becomes count+1 (modulo 256). With `period` = 0, the count stays at 0.
- R8: `match_pulse` is high for exactly one system clock, in the same cycle in which the count first shows 0 after a step taken at `count == period`. It is never high otherwise.
- R9: With `cfg_tick_sync` = 1, a counting step is applied only in the cycle where the free-running 2-bit system-clock divider is at its terminal value 3. A step that arrives earlier waits for that cycle. No step is lost while edges are at least four clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_clk_in | input | 1 | External timer clock, asynchronous to `clk` |
| run_en | input | 1 | Run-enable request |
| period | input | 8 | Period value the count is compared with |
| cfg_fall_edge | input | 1 | 1 selects the falling edge of `tmr_clk_in`, 0 selects the rising edge |
| cfg_run_sync | input | 1 | 1 passes `run_en` through the two-edge enable chain |
| cfg_tick_sync | input | 1 | 1 aligns count steps to the divide-by-four phase |
| count | output | 8 | Current count |
| match_pulse | output | 1 | One-clock pulse on wrap from `period` to 0 |

## Verification
The hardest situations to reach are the tails of the enable chain. With chain synchronization on, two counting edges are still taken after `run_en` falls. An edge-selection change made mid-run must be shown to take no effect until the timer has fully stopped. The stimulus reaches both by driving the timer clock one half-period at a time, and by sampling the count after each single transition: it stops, switches synchronization on, restarts, and changes `cfg_fall_edge` between half-periods while running. A behavioural model in the bench is compared with the count and match outputs on every system clock. The comparison also covers the phase-aligned step timing, which has no explicit port of its own.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;
endpackage

// File: rtl/pmt_edge_sel.sv
module pmt_edge_sel #(
    parameter int IN_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tmr_in,
    input  logic pol_req,
    input  logic running,
    output logic edge_o,
    output logic pol_o
);
    import pmt_pkg::*;

    typedef struct packed {
        logic [IN_STAGES:0] sh;
        edge_pol_e          pol;
    } es_t;

    es_t  st_d, st_q;
    logic lvl_now, lvl_old;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[IN_STAGES-1:0], tmr_in};
        // edge selection frozen while the timer runs
        if (!running) st_d.pol = edge_pol_e'(pol_req);
        lvl_now = st_q.sh[IN_STAGES-1];
        lvl_old = st_q.sh[IN_STAGES];
        edge_o  = (st_q.pol == EDGE_FALL) ? (~lvl_now & lvl_old)
                                          : (lvl_now & ~lvl_old);
        pol_o   = st_q.pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pmt_run_sync.sv
module pmt_run_sync #(
    parameter int EN_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic run_req,
    input  logic sync_sel,
    output logic run_eff
);
    logic [EN_STAGES-1:0] en_d, en_q;

    generate
        if (EN_STAGES == 1) begin : g_single
            always_comb en_d = adv ? run_req : en_q;
        end else begin : g_chain
            always_comb en_d = adv ? {en_q[EN_STAGES-2:0], run_req} : en_q;
        end
    endgenerate

    assign run_eff = sync_sel ? en_q[EN_STAGES-1] : run_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end
endmodule

// File: rtl/pmt_count_core.sv
module pmt_count_core #(
    parameter int W    = 8,
    parameter int PH_W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         tick_sync,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         match,
    output logic         apply_o,
    output logic         pend_o,
    output logic         phase_full_o
);
    localparam logic [W-1:0]    CNT_ONE = 1;
    localparam logic [PH_W-1:0] PH_ONE  = 1;

    typedef struct packed {
        logic [W-1:0]    cnt;
        logic [PH_W-1:0] ph;
        logic            pend;
        logic            match;
    } st_t;

    st_t  st_d, st_q;
    logic ph_full, apply, at_top;

    always_comb begin
        st_d       = st_q;
        ph_full    = &st_q.ph;
        at_top     = (st_q.cnt == period);
        apply      = tick_sync ? ((st_q.pend | tick) & ph_full) : tick;
        st_d.ph    = st_q.ph + PH_ONE;
        st_d.pend  = tick_sync & (st_q.pend | tick) & ~ph_full;
        st_d.match = apply & at_top;
        if (apply) st_d.cnt = at_top ? '0 : st_q.cnt + CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count        = st_q.cnt;
    assign match        = st_q.match;
    assign apply_o      = apply;
    assign pend_o       = st_q.pend;
    assign phase_full_o = ph_full;
endmodule

// File: rtl/period_match_timer.sv
module period_match_timer #(
    parameter int W         = 8,
    parameter int IN_STAGES = 2,
    parameter int EN_STAGES = 2,
    parameter int PH_W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tmr_clk_in,
    input  logic         run_en,
    input  logic [W-1:0] period,
    input  logic         cfg_fall_edge,
    input  logic         cfg_run_sync,
    input  logic         cfg_tick_sync,
    output logic [W-1:0] count,
    output logic         match_pulse
);
    logic cnt_edge, pol_q, run_eff, tick, apply, pend, ph_full;

    pmt_edge_sel #(.IN_STAGES(IN_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .tmr_in  (tmr_clk_in),
        .pol_req (cfg_fall_edge),
        .running (run_eff),
        .edge_o  (cnt_edge),
        .pol_o   (pol_q)
    );

    pmt_run_sync #(.EN_STAGES(EN_STAGES)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (cnt_edge),
        .run_req  (run_en),
        .sync_sel (cfg_run_sync),
        .run_eff  (run_eff)
    );

    assign tick = cnt_edge & run_eff;

    pmt_count_core #(.W(W), .PH_W(PH_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .tick_sync    (cfg_tick_sync),
        .period       (period),
        .count        (count),
        .match        (match_pulse),
        .apply_o      (apply),
        .pend_o       (pend),
        .phase_full_o (ph_full)
    );
endmodule

// File: rtl/period_match_timer_chk.sv
module period_match_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] count,
    input logic [W-1:0] period,
    input logic         match_pulse,
    input logic         run_eff,
    input logic         apply,
    input logic         pend,
    input logic         ph_full,
    input logic         pol_q,
    input logic         cfg_tick_sync
);
    localparam logic [W-1:0] ONE = 1;

    p_hold_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_eff && !pend) |=> $stable(count));

    p_pol_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_eff |=> $stable(pol_q));

    p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && count == period) |=> (count == '0));

    p_step_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && count != period) |=> (count == $past(count) + ONE));

    p_match_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (count == '0));

    p_match_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse);

    p_phase_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tick_sync && apply) |-> ph_full);
endmodule

bind period_match_timer period_match_timer_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .count         (count),
    .period        (period),
    .match_pulse   (match_pulse),
    .run_eff       (run_eff),
    .apply         (apply),
    .pend          (pend),
    .ph_full       (ph_full),
    .pol_q         (pol_q),
    .cfg_tick_sync (cfg_tick_sync)
);

// File: tb/period_match_timer_tb_top.sv
`timescale 1ns/1ps
module period_match_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_clk_in = 1'b0;
    logic       run_en = 1'b0;
    logic [7:0] period = 8'd0;
    logic       cfg_fall_edge = 1'b0;
    logic       cfg_run_sync = 1'b0;
    logic       cfg_tick_sync = 1'b0;
    logic [7:0] count;
    logic       match_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    int pulses = 0;
    bit finished = 1'b0;

    // behavioural reference state
    bit  hist[$] = '{1'b0, 1'b0, 1'b0};
    bit  m_pol = 1'b0, m_e1 = 1'b0, m_e2 = 1'b0, m_pend = 1'b0, m_match = 1'b0;
    int  m_ph = 0;
    int  m_cnt = 0;

    always #10 clk = ~clk;

    period_match_timer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tmr_clk_in    (tmr_clk_in),
        .run_en        (run_en),
        .period        (period),
        .cfg_fall_edge (cfg_fall_edge),
        .cfg_run_sync  (cfg_run_sync),
        .cfg_tick_sync (cfg_tick_sync),
        .count         (count),
        .match_pulse   (match_pulse)
    );

    task automatic model_reset();
        hist = '{1'b0, 1'b0, 1'b0};
        m_pol = 0; m_e1 = 0; m_e2 = 0; m_pend = 0; m_match = 0;
        m_ph = 0; m_cnt = 0;
    endtask

    task automatic model_step();
        bit edge_seen, run, tick, full, app;
        edge_seen = m_pol ? (!hist[1] && hist[2]) : (hist[1] && !hist[2]);
        run  = cfg_run_sync ? m_e2 : run_en;
        tick = edge_seen && run;
        full = (m_ph == 3);
        app  = cfg_tick_sync ? ((m_pend || tick) && full) : tick;
        m_match = app && (m_cnt == int'(period));
        if (app) m_cnt = (m_cnt == int'(period)) ? 0 : (m_cnt + 1) % 256;
        m_pend = cfg_tick_sync && (m_pend || tick) && !full;
        if (!run) m_pol = cfg_fall_edge;
        if (edge_seen) begin
            m_e2 = m_e1;
            m_e1 = run_en;
        end
        m_ph = (m_ph + 1) % 4;
        hist.push_front(tmr_clk_in);
        void'(hist.pop_back());
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    // one system clock: model follows the edge, outputs compared mid-cycle
    task automatic step();
        @(posedge clk);
        if (!rst_n) model_reset();
        else        model_step();
        @(negedge clk);
        check("R7 per-cycle count", int'(count), m_cnt);
        check("R8 per-cycle match", int'(match_pulse), int'(m_match));
        if (match_pulse) pulses++;
    endtask

    task automatic half(input bit lvl);
        tmr_clk_in = lvl;
        repeat (6) step();
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin
            half(1'b1);
            half(1'b0);
        end
    endtask

    initial begin
        @(negedge clk);
        repeat (3) step();
        check("R1 count in reset", int'(count), 0);
        check("R1 match in reset", int'(match_pulse), 0);
        rst_n = 1'b1;
        step();
        check("R1 count after reset", int'(count), 0);

        // rising edge, no synchronisation, period 5
        period = 8'd5;
        run_en = 1'b1;
        cycles(3);
        check("R2 R6 rising edges counted", int'(count), 3);
        pulses = 0;
        cycles(5);
        check("R7 wrap past period", int'(count), 2);
        check("R8 one match pulse per wrap", pulses, 1);

        // stop holds
        run_en = 1'b0;
        cycles(4);
        check("R4 count held while stopped", int'(count), 2);

        // falling edge selected while stopped
        cfg_fall_edge = 1'b1;
        repeat (3) step();
        run_en = 1'b1;
        half(1'b1);
        check("R2 rising ignored in falling mode", int'(count), 2);
        half(1'b0);
        check("R2 falling edge counted", int'(count), 3);

        // polarity change while running ignored
        cfg_fall_edge = 1'b0;
        half(1'b1);
        check("R3 rising ignored while running", int'(count), 3);
        half(1'b0);
        check("R3 falling still counts", int'(count), 4);

        // stop, then two-edge enable chain
        run_en = 1'b0;
        cycles(3);
        check("R4 held after stop", int'(count), 4);
        cfg_run_sync = 1'b1;
        period = 8'd200;
        repeat (2) step();
        run_en = 1'b1;
        cycles(1);
        check("R5 first edge not counted", int'(count), 4);
        cycles(1);
        check("R5 second edge not counted", int'(count), 4);
        cycles(1);
        check("R5 third edge counted", int'(count), 5);
        run_en = 1'b0;
        cycles(1);
        check("R5 stop lag edge one", int'(count), 6);
        cycles(1);
        check("R5 stop lag edge two", int'(count), 7);
        cycles(2);
        check("R5 stopped after chain drains", int'(count), 7);

        // mid-run reset, then period zero
        rst_n = 1'b0;
        repeat (2) step();
        check("R1 count cleared by reset", int'(count), 0);
        rst_n = 1'b1;
        cfg_run_sync = 1'b0;
        period = 8'd0;
        step();
        run_en = 1'b1;
        pulses = 0;
        cycles(4);
        check("R7 period zero stays zero", int'(count), 0);
        check("R8 pulse each step at period zero", pulses, 4);

        // phase-aligned steps
        run_en = 1'b0;
        cycles(1);
        period = 8'd9;
        cfg_tick_sync = 1'b1;
        step();
        run_en = 1'b1;
        cycles(6);
        check("R9 aligned steps not lost", int'(count), 6);
        pulses = 0;
        cycles(5);
        check("R9 wrap with aligned steps", int'(count), 1);
        check("R8 single pulse with aligned steps", pulses, 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule